// File: doc/BRIEF.md
# Direction-Switched Radio Data FIFO

This block is a four-entry, ten-bit FIFO placed between a host microcontroller and a radio packet framer. Each word holds eight payload bits in bits 7:0 and two metadata bits in bits 9:8. The framer uses the metadata for packet start/end markers and the CRC verdict; the FIFO carries all ten bits unchanged. A single storage array serves both directions. With `tx_mode` high the host fills the FIFO and the framer drains it. With `tx_mode` low the framer fills it and the host drains it.

The host can poll the fill count and the status flags. It can also rely on a level-sensitive interrupt whose sources are gated one by one through an enable mask. The interrupt has no acknowledge: it drops only when no enabled condition holds any more. For the SPI slave there is a status byte, captured on the first serial clock edge of an address phase and held for the rest of it. The slave shifts this byte out while the address comes in.

Top module: `dirfifo`

## Requirements
- R1: Words leave in the order they were accepted, all ten bits intact. The active reader's data port shows the head word combinationally while the FIFO holds data, and shows zero when it is empty. The inactive reader's data port always shows zero.
- R2: After reset the FIFO is empty: `fill_count` is 0, `empty` is 1, `full` is 0, the sticky flags are 0 and `spi_status` is 0x00. `fill_count` ranges from 0 to 4, with `empty` = (count==0) and `full` = (count==4).
- R3: With `tx_mode`=1 only `host_wr_en` and `frm_rd_en` act. With `tx_mode`=0 only `frm_wr_en` and `host_rd_en` act. Strobes from the inactive side change nothing.
- R4: A write while the FIFO is full and no read happens in the same cycle discards the word and sets the sticky `overrun`.
- R5: A read while the FIFO is empty returns zero and sets the sticky `underrun`. A write in that same cycle is still stored, so the count becomes 1.
- R6: A one-cycle `clr_err` clears both sticky flags. A new error event in the same cycle wins over the clear.
- R7: A read and a write in the same cycle leave the count unchanged whenever the FIFO holds data. This includes the full case, where the write is accepted and no overrun is raised.
- R8: Any change of `tx_mode` empties the FIFO and clears both sticky flags at the next edge. All data strobes in that cycle are ignored.
- R9: `irq` is high exactly when an enabled source holds. The `irq_mask` bits are: bit0 empty, bit1 not empty, bit2 full, bit3 not full, bit4 count >= `irq_level`. `irq` stays high for as long as the condition holds, with no acknowledge.
- R10: `spi_status` bit layout: bit0 empty, bit1 full, bit2 overrun, bit3 underrun, bits 5:4 the head word's bits 9:8 (zero when empty), bits 7:6 zero. It is loaded on the first `spi_sclk_edge` while `spi_addr_phase` is high and is held until the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 1 | 1: host writes, framer reads; 0: framer writes, host reads |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 10 | Host write word |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 10 | Head word for the host |
| frm_wr_en | input | 1 | Framer write strobe |
| frm_wr_data | input | 10 | Framer write word |
| frm_rd_en | input | 1 | Framer read strobe |
| frm_rd_data | output | 10 | Head word for the framer |
| clr_err | input | 1 | Clears the sticky overrun and underrun flags |
| irq_mask | input | 5 | Interrupt source enables |
| irq_level | input | 3 | Fill threshold for the level source |
| fill_count | output | 3 | Entries held |
| empty | output | 1 | FIFO holds nothing |
| full | output | 1 | FIFO holds four entries |
| overrun | output | 1 | Sticky: write was discarded |
| underrun | output | 1 | Sticky: read found FIFO empty |
| irq | output | 1 | Level interrupt, active high |
| spi_addr_phase | input | 1 | High while the SPI address is shifted in |
| spi_sclk_edge | input | 1 | One-cycle pulse per serial clock edge |
| spi_status | output | 8 | Status byte for the SPI address phase |

## Verification
The checker assumes that `spi_sclk_edge` pulses only in step with the system clock and that the reset lasts at least one edge, so every `$past` value is defined. It also assumes that `tx_mode` is a plain synchronous level. The bench drives every input on the falling edge, holds reset for three cycles, changes `tx_mode` only between strobes, and raises address-phase edges only as single-cycle pulses. Flush, interrupt and hold properties are therefore evaluated on clean sampled values.

// File: rtl/dirfifo_pkg.sv
package dirfifo_pkg;

    localparam int DATA_W = 8;
    localparam int META_W = 2;
    localparam int WORD_W = DATA_W + META_W;
    localparam int N_SRC  = 5;

    localparam int SRC_EMPTY  = 0;
    localparam int SRC_NEMPTY = 1;
    localparam int SRC_FULL   = 2;
    localparam int SRC_NFULL  = 3;
    localparam int SRC_LEVEL  = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [META_W-1:0] meta_t;

    typedef struct packed {
        logic [1:0] rsvd;
        meta_t      meta;
        logic       underrun;
        logic       overrun;
        logic       full;
        logic       empty;
    } spi_stat_t;

    function automatic meta_t word_meta(input word_t w);
        return w[WORD_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/dirfifo_store.sv
module dirfifo_store
    import dirfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr,
    input  word_t            wdata,
    input  logic             rd,
    output word_t            head,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full,
    output logic             ovf_evt,
    output logic             unf_evt
);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (count == '0);
    assign is_full  = (count == CNT_W'(DEPTH));
    assign rd_ok    = rd && !is_empty && !flush;
    assign wr_ok    = wr && (!is_full || rd_ok) && !flush;
    assign ovf_evt  = wr && is_full && !rd && !flush;
    assign unf_evt  = rd && is_empty && !flush;
    assign head     = is_empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= bump(wp);
            if (rd_ok) rp <= bump(rp);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/dirfifo_irq.sv
module dirfifo_irq
    import dirfifo_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             is_empty,
    input  logic             is_full,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic [N_SRC-1:0] mask,
    output logic             irq
);

    logic [N_SRC-1:0] src;

    always_comb begin
        src             = '0;
        src[SRC_EMPTY]  = is_empty;
        src[SRC_NEMPTY] = !is_empty;
        src[SRC_FULL]   = is_full;
        src[SRC_NFULL]  = !is_full;
        src[SRC_LEVEL]  = (count >= level);
    end

    assign irq = |(src & mask);

endmodule

// File: rtl/dirfifo_spistat.sv
module dirfifo_spistat
    import dirfifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      addr_phase,
    input  logic      sclk_pulse,
    input  spi_stat_t live,
    output logic [7:0] status
);

    logic taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken  <= 1'b0;
            status <= '0;
        end else if (!addr_phase) begin
            taken <= 1'b0;
        end else if (sclk_pulse && !taken) begin
            taken  <= 1'b1;
            status <= live;
        end
    end

endmodule

// File: rtl/dirfifo.sv
module dirfifo
    import dirfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_mode,
    input  logic             host_wr_en,
    input  logic [9:0]       host_wr_data,
    input  logic             host_rd_en,
    output logic [9:0]       host_rd_data,
    input  logic             frm_wr_en,
    input  logic [9:0]       frm_wr_data,
    input  logic             frm_rd_en,
    output logic [9:0]       frm_rd_data,
    input  logic             clr_err,
    input  logic [4:0]       irq_mask,
    input  logic [CNT_W-1:0] irq_level,
    output logic [CNT_W-1:0] fill_count,
    output logic             empty,
    output logic             full,
    output logic             overrun,
    output logic             underrun,
    output logic             irq,
    input  logic             spi_addr_phase,
    input  logic             spi_sclk_edge,
    output logic [7:0]       spi_status
);

    logic      mode_q, flush;
    logic      wr, rd, ovf_evt, unf_evt;
    word_t     wdata, head;
    spi_stat_t live;

    assign flush = (tx_mode != mode_q);
    assign wr    = tx_mode ? host_wr_en   : frm_wr_en;
    assign wdata = tx_mode ? host_wr_data : frm_wr_data;
    assign rd    = tx_mode ? frm_rd_en    : host_rd_en;

    assign host_rd_data = tx_mode ? '0 : head;
    assign frm_rd_data  = tx_mode ? head : '0;

    always_ff @(posedge clk) begin
        mode_q <= tx_mode;
        if (rst || flush) begin
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (ovf_evt)      overrun <= 1'b1;
            else if (clr_err) overrun <= 1'b0;
            if (unf_evt)      underrun <= 1'b1;
            else if (clr_err) underrun <= 1'b0;
        end
    end

    dirfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr      (wr),
        .wdata   (wdata),
        .rd      (rd),
        .head    (head),
        .count   (fill_count),
        .is_empty(empty),
        .is_full (full),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt)
    );

    dirfifo_irq #(.CNT_W(CNT_W)) u_irq (
        .is_empty(empty),
        .is_full (full),
        .count   (fill_count),
        .level   (irq_level),
        .mask    (irq_mask),
        .irq     (irq)
    );

    always_comb begin
        live          = '0;
        live.empty    = empty;
        live.full     = full;
        live.overrun  = overrun;
        live.underrun = underrun;
        live.meta     = word_meta(head);
    end

    dirfifo_spistat u_spistat (
        .clk       (clk),
        .rst       (rst),
        .addr_phase(spi_addr_phase),
        .sclk_pulse(spi_sclk_edge),
        .live      (live),
        .status    (spi_status)
    );

endmodule

// File: rtl/dirfifo_chk.sv
module dirfifo_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_mode,
    input logic [CNT_W-1:0] fill_count,
    input logic             empty,
    input logic             overrun,
    input logic             underrun,
    input logic             irq,
    input logic [4:0]       irq_mask,
    input logic             spi_addr_phase,
    input logic             spi_sclk_edge,
    input logic [7:0]       spi_status
);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CNT_W'(DEPTH));

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        {1'b0, fill_count} <= {1'b0, $past(fill_count)} + 1'b1);

    a_r8_flush: assert property (@(posedge clk) disable iff (rst)
        (tx_mode != $past(tx_mode)) |=> (fill_count == '0 && !overrun && !underrun));

    a_r9_no_mask: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == 5'b0) |-> !irq);

    a_r9_empty_src: assert property (@(posedge clk) disable iff (rst)
        (irq_mask[0] && empty) |-> irq);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (spi_addr_phase && $past(spi_addr_phase) && $past(spi_sclk_edge)) |=> $stable(spi_status));

endmodule

bind dirfifo dirfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_mode       (tx_mode),
    .fill_count    (fill_count),
    .empty         (empty),
    .overrun       (overrun),
    .underrun      (underrun),
    .irq           (irq),
    .irq_mask      (irq_mask),
    .spi_addr_phase(spi_addr_phase),
    .spi_sclk_edge (spi_sclk_edge),
    .spi_status    (spi_status)
);

// File: tb/dirfifo_bench.sv
`timescale 1ns/1ps
module dirfifo_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_mode = 1'b1;
    logic       host_wr_en = 0, host_rd_en = 0, frm_wr_en = 0, frm_rd_en = 0;
    logic [9:0] host_wr_data = '0, frm_wr_data = '0;
    logic [9:0] host_rd_data, frm_rd_data;
    logic       clr_err = 0;
    logic [4:0] irq_mask = '0;
    logic [2:0] irq_level = '0;
    logic [2:0] fill_count;
    logic       empty, full, overrun, underrun, irq;
    logic       spi_addr_phase = 0, spi_sclk_edge = 0;
    logic [7:0] spi_status;

    int n_chk = 0;
    int n_bad = 0;
    int mcount = 0;
    logic [9:0] exp_q[$];
    bit done = 0;

    always #4 clk = ~clk;

    dirfifo u_dirfifo (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: write on the active side, push expected word when it fits
    task automatic put(input logic [9:0] w);
        if (tx_mode) begin host_wr_en = 1; host_wr_data = w; end
        else begin frm_wr_en = 1; frm_wr_data = w; end
        step();
        host_wr_en = 0; frm_wr_en = 0;
        if (mcount < 4) begin exp_q.push_back(w); mcount++; end
    endtask

    // monitor: read on the active side, pop and compare
    task automatic take(input string req);
        logic [9:0] got, exp;
        if (tx_mode) frm_rd_en = 1; else host_rd_en = 1;
        #1;
        got = tx_mode ? frm_rd_data : host_rd_data;
        if (exp_q.size() > 0) begin exp = exp_q.pop_front(); mcount--; end
        else exp = '0;
        check(req, got, exp);
        step();
        frm_rd_en = 0; host_rd_en = 0;
    endtask

    // simultaneous write and read on the active side
    task automatic both(input logic [9:0] w, input string req);
        logic [9:0] got, exp;
        if (tx_mode) begin host_wr_en = 1; host_wr_data = w; frm_rd_en = 1; end
        else begin frm_wr_en = 1; frm_wr_data = w; host_rd_en = 1; end
        #1;
        got = tx_mode ? frm_rd_data : host_rd_data;
        if (exp_q.size() > 0) begin exp = exp_q.pop_front(); mcount--; end
        else exp = '0;
        check(req, got, exp);
        exp_q.push_back(w); mcount++;
        step();
        host_wr_en = 0; frm_wr_en = 0; host_rd_en = 0; frm_rd_en = 0;
    endtask

    task automatic pulse_edge();
        spi_sclk_edge = 1;
        step();
        spi_sclk_edge = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R2 reset state
        check("R2 count", fill_count, 0);
        check("R2 empty", empty, 1);
        check("R2 full", full, 0);
        check("R2 sticky", {overrun, underrun}, 0);
        check("R2 spi", spi_status, 8'h00);
        check("R9 irq masked", irq, 0);

        // R1 order with metadata
        put(10'h3A5); put(10'h100); put(10'h2FF);
        check("R2 count3", fill_count, 3);
        take("R1 w0"); take("R1 w1"); take("R1 w2");

        // R5 underrun
        take("R5 empty read zero");
        check("R5 underrun", underrun, 1);
        clr_err = 1; step(); clr_err = 0;
        check("R6 clear", underrun, 0);

        // R4 overrun
        put(10'h001); put(10'h102); put(10'h203); put(10'h304);
        check("R2 full", full, 1);
        put(10'h0AA);
        check("R4 overrun", overrun, 1);
        check("R4 count", fill_count, 4);
        take("R4 d0"); take("R4 d1"); take("R4 d2"); take("R4 d3");
        check("R4 dropped", empty, 1);
        clr_err = 1; step(); clr_err = 0;
        check("R6 clear ovr", overrun, 0);

        // R3 inactive side
        put(10'h011); put(10'h022);
        frm_wr_en = 1; frm_wr_data = 10'h3FF; host_rd_en = 1;
        #1 check("R3 host rd zero", host_rd_data, 0);
        step();
        frm_wr_en = 0; host_rd_en = 0;
        check("R3 count", fill_count, 2);
        check("R3 no underrun", underrun, 0);

        // R7 simultaneous
        both(10'h033, "R7 mid read");
        check("R7 count", fill_count, 2);
        put(10'h044); put(10'h055);
        both(10'h066, "R7 full read");
        check("R7 full count", fill_count, 4);
        check("R7 no overrun", overrun, 0);
        take("R7 d0"); take("R7 d1"); take("R7 d2"); take("R7 d3");

        // R5 empty with write
        both(10'h077, "R5 read zero");
        check("R5 underrun both", underrun, 1);
        check("R5 count1", fill_count, 1);

        // R8 flush on direction change
        tx_mode = 0;
        step();
        check("R8 count", fill_count, 0);
        check("R8 flags", {overrun, underrun}, 0);
        exp_q.delete(); mcount = 0;

        // R3 receive direction
        put(10'h2C1); put(10'h1C2);
        take("R3 rx0"); take("R3 rx1");

        // R9 interrupt sources
        irq_mask = 5'b00001; #1 check("R9 empty", irq, 1);
        irq_mask = 5'b00010; #1 check("R9 nempty off", irq, 0);
        step();
        put(10'h1A0);
        check("R9 nempty", irq, 1);
        irq_mask = 5'b01000; #1 check("R9 nfull", irq, 1);
        irq_mask = 5'b00100; #1 check("R9 full off", irq, 0);
        step();
        put(10'h2A1); put(10'h3A2); put(10'h0A3);
        check("R9 full", irq, 1);
        step(); step(); step();
        check("R9 held", irq, 1);
        irq_mask = 5'b10000; irq_level = 3'd4; #1 check("R9 lvl4", irq, 1);
        step();
        take("R1 rx a0");
        check("R9 lvl4 drop", irq, 0);
        irq_level = 3'd3; #1 check("R9 lvl3", irq, 1);
        irq_mask = 5'b0;
        step();

        // R10 spi status: head 0x2A1 meta 10 -> 0x20
        spi_addr_phase = 1;
        pulse_edge();
        check("R10 capture", spi_status, 8'h20);
        take("R1 rx a1");
        pulse_edge();
        check("R10 hold", spi_status, 8'h20);
        spi_addr_phase = 0;
        step();
        take("R1 rx a2");
        spi_addr_phase = 1;
        step();
        check("R10 no edge", spi_status, 8'h20);
        pulse_edge();
        check("R10 recapture", spi_status, 8'h00);
        spi_addr_phase = 0;
        step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule